// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into memory buffers described by a circular chain of descriptors. Each descriptor is four 32-bit words: a status/length word, a buffer address, an unused word, and the address of the next descriptor. After a start pulse the engine reads the descriptor at the list base address. It checks that the DMA side owns the descriptor and loads the buffer and link addresses. It then packs the bytes of one frame into words and writes them into the buffer. When the frame ends, it writes back a status word that hands the descriptor to the CPU, and it follows the link to the next descriptor.

If a fetched descriptor is still owned by the CPU, the engine flags "descriptor unavailable". It then keeps accepting stream bytes and throws them away until software pulses the demand input. The demand pulse makes the engine re-read the same descriptor. Interrupt causes are collected in a sticky status vector, and each bit is cleared by writing a one to it.

Addresses on the memory port are word addresses. A read issued in one cycle returns its data on `mem_rdata` in the next cycle. A write completes in the cycle it is issued.

Top module: `rxd_dma_engine`

## Requirements
- R1: During and after reset, and until a start pulse, the engine keeps `mem_rd`, `mem_wr` and `fr_ready` low and `int_status` at zero.
- R2: A `ring_start` pulse while idle makes the engine fetch its first descriptor from `list_base`. It reads word 0 (status), word 1 (buffer address) and word 3 (next address).
- R3: A descriptor belongs to the engine only when bit 31 of its status word is 1, so owner values 10 and 11 qualify. With owner 00 or 01, the engine sets `int_status` bit 10, raises `fr_ready`, and discards every byte without touching memory.
- R4: A `demand` pulse while stalled makes the engine re-read the same descriptor.
- R5: The frame's bytes are packed little-endian, byte n of the frame in bits 8*(n mod 4)+7 down to 8*(n mod 4) of buffer word n/4. Words go to consecutive addresses from the buffer address, and a partial last word has its unused upper bytes at zero.
- R6: After the last buffer write, the engine writes the status word to descriptor word 0. The word carries bits 31:30 = 00, the stored byte count in bits 15:0, and bit 16 set.
- R7: Status bit 17 reports a CRC error flagged with the last byte. Bit 22 reports a runt, meaning fewer than MIN_LEN (64) bytes. Bit 20 marks a good frame and is set only when no error bit is set.
- R8: A frame longer than MAX_LEN (1536) bytes is cut off: only MAX_LEN bytes are stored, the count reads MAX_LEN, and status bit 19 is set.
- R9: The next descriptor comes from the link word (word 3), so a ring of any shape wraps back to its first descriptor.
- R10: `int_status` bit 0 sets on every completed frame, bit 4 on a good frame, bit 1 on a CRC error, and bit 10 when a descriptor is unavailable. The bits stay set until cleared through `int_clear` (write one to clear). A set in the same cycle wins over a clear.
- R11: Bytes that arrive outside a frame (before any start-of-frame byte) are dropped and cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| list_base | input | AW | Word address of the first descriptor |
| ring_start | input | 1 | Start pulse, taken while idle |
| demand | input | 1 | Resume pulse, taken while stalled |
| fr_valid | input | 1 | Stream byte valid |
| fr_data | input | 8 | Stream byte |
| fr_sof | input | 1 | Byte is the first of a frame |
| fr_eof | input | 1 | Byte is the last of a frame |
| fr_crc_err | input | 1 | CRC error, meaningful with the last byte |
| fr_ready | output | 1 | Engine takes a byte this cycle |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| int_clear | input | 11 | Write-one-to-clear mask for interrupt status |
| int_status | output | 11 | Sticky interrupt status |

## Verification
The frames differ in length and error flag so that each one exercises a separate path:
- an exact-minimum good frame, which fills only whole words;
- a CRC-error frame ending in a half-filled word;
- an oversize frame that has to be truncated;
- a short runt.

Together they separate the packing, the length cap and the encoding of every status bit. A scoreboard predicts every memory write in order, so a missing buffer word, a wrong lane order or a status write that comes too early all show up as mismatches. Descriptors with owner codes 11, 10, 01 and 00 tell the bit-31 ownership test apart from a test of the whole field. A frame sent during a stall, and stray bytes sent before a frame starts, must both produce no write at all.

// File: rtl/rxd_pkg.sv
// Shared types and bit positions for the receive descriptor engine.
// Assumes descriptors of four 32-bit words addressed by word.
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_CHK_STAT,
        ST_LD_BUF,
        ST_LD_NXT,
        ST_RECV,
        ST_WB,
        ST_STALL
    } rxd_state_e;

    localparam int DESC_BUF_OFS = 1;
    localparam int DESC_NXT_OFS = 3;

    localparam int SB_OWN_DMA = 31;
    localparam int SB_IRQ     = 16;
    localparam int SB_CRC     = 17;
    localparam int SB_LONG    = 19;
    localparam int SB_GOOD    = 20;
    localparam int SB_RUNT    = 22;

    localparam int INT_W       = 11;
    localparam int INT_RX      = 0;
    localparam int INT_CRC     = 1;
    localparam int INT_GOOD    = 4;
    localparam int INT_UNAVAIL = 10;

    // Builds the write-back word; owner bits stay 00 to hand over to the CPU.
    function automatic logic [31:0] make_status(input logic [15:0] cnt,
                                                input logic crc,
                                                input logic too_long,
                                                input logic runt);
        logic [31:0] w;
        w = 32'h0;
        w[15:0]    = cnt;
        w[SB_IRQ]  = 1'b1;
        w[SB_CRC]  = crc;
        w[SB_LONG] = too_long;
        w[SB_RUNT] = runt;
        w[SB_GOOD] = !(crc || too_long || runt);
        return w;
    endfunction

endpackage

// File: rtl/rxd_packer.sv
// Byte-to-word packer for one frame at a time.
// Tracks the stored byte count, truncation and CRC flags, and emits a word
// write each time a word fills or the frame ends. Assumes MAX_LEN is a
// multiple of four so no partial word is pending when bytes start dropping.
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_LEN = 1536,
    parameter int CW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_acc,
    input  logic [7:0]    byte_data,
    input  logic          sof,
    input  logic          eof,
    input  logic          crc_err,
    input  logic [AW-1:0] buf_base,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          done,
    output logic [CW-1:0] cnt,
    output logic          crc,
    output logic          too_long
);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          long_q;
    logic          crc_q;
    logic [31:0]   pack_q;

    logic [CW-1:0] base_cnt;
    logic          live;
    logic          store;
    logic [1:0]    lane;
    logic [31:0]   word;

    // Works out where the incoming byte lands and whether a word is complete.
    always_comb begin
        base_cnt = sof ? '0 : cnt_q;
        live     = byte_acc && (sof || active_q);
        store    = live && (base_cnt < CW'(MAX_LEN));
        lane     = base_cnt[1:0];
        word     = sof ? 32'h0 : pack_q;
        word[{lane, 3'b000} +: 8] = byte_data;
        wr_en    = store && ((lane == 2'd3) || eof);
        wr_addr  = buf_base + AW'(base_cnt >> 2);
        wr_data  = word;
        done     = live && eof;
    end

    // Holds the frame state between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            long_q   <= 1'b0;
            crc_q    <= 1'b0;
            pack_q   <= 32'h0;
        end else if (live) begin
            active_q <= !eof;
            cnt_q    <= store ? base_cnt + CW'(1) : base_cnt;
            long_q   <= (sof ? 1'b0 : long_q) | !store;
            if (store) begin
                pack_q <= wr_en ? 32'h0 : word;
            end
            if (eof) begin
                crc_q <= crc_err;
            end
        end
    end

    assign cnt      = cnt_q;
    assign crc      = crc_q;
    assign too_long = long_q;

    assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_LEN));

    assert_drop_marks_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !store) |=> long_q);

endmodule

// File: rtl/rxd_irq.sv
// Sticky interrupt status with write-one-to-clear; a set beats a clear.
module rxd_irq #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);

    // Accumulates causes and applies clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/rxd_dma_engine.sv
// Receive descriptor ring engine.
// Fetches a descriptor, checks bit 31 of its status for DMA ownership, fills
// the buffer from the frame stream, writes the status back with owner 00 and
// follows the link word. Assumes a memory that accepts every request and
// returns read data one cycle after the request.
module rxd_dma_engine
    import rxd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_LEN = 1536,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    list_base,
    input  logic             ring_start,
    input  logic             demand,
    input  logic             fr_valid,
    input  logic [7:0]       fr_data,
    input  logic             fr_sof,
    input  logic             fr_eof,
    input  logic             fr_crc_err,
    output logic             fr_ready,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic [INT_W-1:0] int_clear,
    output logic [INT_W-1:0] int_status
);

    localparam int CW    = $clog2(MAX_LEN + 1);
    localparam int WORDS = (MAX_LEN + 3) / 4;

    rxd_state_e    state_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] nxt_q;

    logic          acc;
    logic          pk_wr;
    logic [AW-1:0] pk_addr;
    logic [31:0]   pk_data;
    logic          pk_done;
    logic [CW-1:0] pk_cnt;
    logic          pk_crc;
    logic          pk_long;
    logic          runt;
    logic [31:0]   status_word;
    logic          owned;
    logic [INT_W-1:0] int_set;

    assign acc      = fr_valid && (state_q == ST_RECV);
    assign fr_ready = (state_q == ST_RECV) || (state_q == ST_STALL);
    assign owned    = mem_rdata[SB_OWN_DMA];

    rxd_packer #(
        .AW      (AW),
        .MAX_LEN (MAX_LEN),
        .CW      (CW)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_acc (acc),
        .byte_data(fr_data),
        .sof      (fr_sof),
        .eof      (fr_eof),
        .crc_err  (fr_crc_err),
        .buf_base (buf_q),
        .wr_en    (pk_wr),
        .wr_addr  (pk_addr),
        .wr_data  (pk_data),
        .done     (pk_done),
        .cnt      (pk_cnt),
        .crc      (pk_crc),
        .too_long (pk_long)
    );

    // Forms the write-back word from the packer's frame summary.
    always_comb begin
        runt        = pk_cnt < CW'(MIN_LEN);
        status_word = make_status(16'(pk_cnt), pk_crc, pk_long, runt);
    end

    // Collects the interrupt causes for this cycle.
    always_comb begin
        int_set              = '0;
        int_set[INT_RX]      = (state_q == ST_WB);
        int_set[INT_GOOD]    = (state_q == ST_WB) && status_word[SB_GOOD];
        int_set[INT_CRC]     = (state_q == ST_WB) && pk_crc;
        int_set[INT_UNAVAIL] = (state_q == ST_CHK_STAT) && !owned;
    end

    rxd_irq #(
        .W(INT_W)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(int_set),
        .clr_vec(int_clear),
        .status (int_status)
    );

    // Drives the single memory port according to the current step.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = 32'h0;
        case (state_q)
            ST_RD_STAT: begin
                mem_rd = 1'b1;
            end
            ST_CHK_STAT: begin
                mem_rd   = owned;
                mem_addr = cur_q + AW'(DESC_BUF_OFS);
            end
            ST_LD_BUF: begin
                mem_rd   = 1'b1;
                mem_addr = cur_q + AW'(DESC_NXT_OFS);
            end
            ST_RECV: begin
                mem_wr    = pk_wr;
                mem_addr  = pk_addr;
                mem_wdata = pk_data;
            end
            ST_WB: begin
                mem_wr    = 1'b1;
                mem_wdata = status_word;
            end
            default: begin
            end
        endcase
    end

    // Steps through fetch, receive, write-back and stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            buf_q   <= '0;
            nxt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ring_start) begin
                        cur_q   <= list_base;
                        state_q <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT:  state_q <= ST_CHK_STAT;
                ST_CHK_STAT: state_q <= owned ? ST_LD_BUF : ST_STALL;
                ST_LD_BUF: begin
                    buf_q   <= mem_rdata[AW-1:0];
                    state_q <= ST_LD_NXT;
                end
                ST_LD_NXT: begin
                    nxt_q   <= mem_rdata[AW-1:0];
                    state_q <= ST_RECV;
                end
                ST_RECV: begin
                    if (pk_done) begin
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    cur_q   <= nxt_q;
                    state_q <= ST_RD_STAT;
                end
                ST_STALL: begin
                    if (demand) begin
                        state_q <= ST_RD_STAT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!mem_rd && !mem_wr && !fr_ready));

    assert_stall_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (!mem_rd && !mem_wr));

    assert_unavail_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_CHK_STAT && state_q == ST_STALL) |-> int_status[INT_UNAVAIL]);

    assert_wb_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB) |-> ($past(state_q) == ST_RECV && $past(fr_valid && fr_eof)));

    assert_buf_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && state_q == ST_RECV) |-> (mem_addr >= buf_q && mem_addr < buf_q + AW'(WORDS)));

    assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/rxd_dma_engine_tb.sv
`timescale 1ns/1ps
module rxd_dma_engine_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          ring_start = 1'b0;
    logic          demand = 1'b0;
    logic          fr_valid = 1'b0;
    logic [7:0]    fr_data = 8'h0;
    logic          fr_sof = 1'b0;
    logic          fr_eof = 1'b0;
    logic          fr_crc_err = 1'b0;
    logic          fr_ready;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic [10:0]   int_clear = '0;
    logic [10:0]   int_status;

    logic          bw = 1'b0;
    logic [10:0]   ba = '0;
    logic [31:0]   bd = '0;
    logic [31:0]   mem [0:2047];

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    string       exp_tag  [$];
    logic [31:0] ea, ed;
    string       et;

    always #10 clk = ~clk;

    rxd_dma_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .list_base (list_base),
        .ring_start(ring_start),
        .demand    (demand),
        .fr_valid  (fr_valid),
        .fr_data   (fr_data),
        .fr_sof    (fr_sof),
        .fr_eof    (fr_eof),
        .fr_crc_err(fr_crc_err),
        .fr_ready  (fr_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .int_clear (int_clear),
        .int_status(int_status)
    );

    // Memory model: one-cycle read latency, bench pokes take priority.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (bw) mem[ba] <= bd;
            else if (mem_wr) mem[mem_addr[10:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[10:0]];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every memory write must match the next prediction.
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            if (exp_addr.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R3 R11 unexpected write: actual %h@%h expected none",
                         mem_wdata, mem_addr);
            end else begin
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                et = exp_tag.pop_front();
                chk(et, "write address", mem_addr, ea);
                chk(et, "write data", mem_wdata, ed);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    function automatic logic [7:0] fb(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i);
    endfunction

    // Driver side of the scoreboard: predicts buffer words then the status word.
    task automatic push_frame(input int len, input logic [7:0] seed,
                              input logic [31:0] bufa, input logic [31:0] desc,
                              input logic [31:0] st, input string st_tag);
        int stored;
        int nw;
        logic [31:0] w;
        stored = (len > 1536) ? 1536 : len;
        nw = (stored + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            w = 32'h0;
            for (int l = 0; l < 4; l++) begin
                if (4 * k + l < stored) w[8*l +: 8] = fb(seed, 4 * k + l);
            end
            exp_addr.push_back(bufa + 32'(k));
            exp_data.push_back(w);
            exp_tag.push_back("R5");
        end
        exp_addr.push_back(desc);
        exp_data.push_back(st);
        exp_tag.push_back(st_tag);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic s, input logic e,
                             input logic c);
        tick();
        while (!fr_ready) tick();
        fr_valid   = 1'b1;
        fr_data    = b;
        fr_sof     = s;
        fr_eof     = e;
        fr_crc_err = c;
    endtask

    task automatic end_stream();
        tick();
        fr_valid = 1'b0;
        fr_sof   = 1'b0;
        fr_eof   = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic crc);
        for (int i = 0; i < len; i++)
            send_byte(fb(seed, i), i == 0, i == len - 1, crc && (i == len - 1));
        end_stream();
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_addr.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (8) @(negedge clk);
        chk(req, "pending predicted writes", 32'(exp_addr.size()), 32'd0);
    endtask

    task automatic poke(input logic [10:0] a, input logic [31:0] d);
        tick();
        bw = 1'b1; ba = a; bd = d;
        tick();
        bw = 1'b0;
    endtask

    task automatic clear_ints();
        tick();
        int_clear = 11'h7FF;
        tick();
        int_clear = 11'h0;
        @(negedge clk);
        chk("R10", "int_status after clear", 32'(int_status), 32'h0);
    endtask

    task automatic pulse_demand();
        tick();
        demand = 1'b1;
        tick();
        demand = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", "int_status in reset", 32'(int_status), 32'h0);
        chk("R1", "fr_ready in reset", 32'(fr_ready), 32'h0);
        chk("R1", "mem_rd/mem_wr in reset", {30'h0, mem_rd, mem_wr}, 32'h0);
        rst_n = 1'b1;
        // Ring: 0x10 -> 0x20 -> 0x30 -> 0x10; owner codes 10, 11, 10.
        poke(11'h010, 32'h8000_0000); poke(11'h011, 32'h100); poke(11'h013, 32'h20);
        poke(11'h020, 32'hC000_0000); poke(11'h021, 32'h280); poke(11'h023, 32'h30);
        poke(11'h030, 32'h8000_0000); poke(11'h031, 32'h400); poke(11'h033, 32'h10);
        repeat (3) @(negedge clk);
        chk("R1", "quiet before start", {29'h0, fr_ready, mem_rd, mem_wr}, 32'h0);

        list_base = 32'h10;
        tick();
        ring_start = 1'b1;
        tick();
        ring_start = 1'b0;

        // R2 R6 R7: good 64-byte frame, whole words only.
        push_frame(64, 8'h11, 32'h100, 32'h10, 32'h0011_0040, "R2 R6 R7");
        send_frame(64, 8'h11, 1'b0);
        drain("R2");
        chk("R10", "int after good frame", 32'(int_status), 32'h011);
        clear_ints();

        // R7: CRC error, 70 bytes ending in a half word, owner 11 descriptor.
        push_frame(70, 8'h40, 32'h280, 32'h20, 32'h0003_0046, "R3 R7");
        send_frame(70, 8'h40, 1'b1);
        drain("R7");
        chk("R10", "int after crc frame", 32'(int_status), 32'h003);
        clear_ints();

        // R8: oversize frame, then the ring wraps to the CPU-owned first entry.
        push_frame(1540, 8'h07, 32'h400, 32'h30, 32'h0009_0600, "R8");
        send_frame(1540, 8'h07, 1'b0);
        drain("R8");
        chk("R10", "int after long frame and stall", 32'(int_status), 32'h401);
        chk("R3", "fr_ready while stalled", 32'(fr_ready), 32'h1);

        // R3: a frame during the stall is discarded.
        send_frame(20, 8'h55, 1'b0);
        repeat (10) @(negedge clk);
        chk("R3", "descriptor untouched during stall", mem[11'h010], 32'h0011_0040);

        // R4: demand re-reads; owner 01 is still not the engine's.
        clear_ints();
        poke(11'h010, 32'h4000_0000);
        pulse_demand();
        repeat (10) @(negedge clk);
        chk("R4", "refetch of owner 01 stalls again", 32'(int_status), 32'h400);

        clear_ints();
        poke(11'h010, 32'h8000_0000);
        pulse_demand();
        repeat (10) @(negedge clk);
        chk("R4", "no unavailable flag after resume", 32'(int_status), 32'h000);

        // R11: stray bytes with no start of frame are dropped.
        send_byte(8'hEE, 1'b0, 1'b0, 1'b0);
        send_byte(8'hEF, 1'b0, 1'b0, 1'b0);
        send_byte(8'hF0, 1'b0, 1'b0, 1'b0);
        end_stream();
        repeat (4) @(negedge clk);
        chk("R11", "no writes after stray bytes", 32'(mem_wr), 32'h0);

        // R7 R9: runt frame lands in the wrapped-to first buffer.
        push_frame(10, 8'hA0, 32'h100, 32'h10, 32'h0041_000A, "R7 R9");
        send_frame(10, 8'hA0, 1'b0);
        drain("R9");
        chk("R10", "int after runt and stall", 32'(int_status), 32'h401);
        chk("R6", "status in memory", mem[11'h010], 32'h0041_000A);

        summary();
        $finish;
    end

endmodule